// File: doc/BRIEF.md
# Synchronized PN Despreader with Majority Decision

This block recovers a 4-bit message from a 60-chip direct-sequence spread frame that arrives one chip at a time. A local 4-stage linear feedback shift register regenerates the 15-chip spreading code in step with the incoming chips. Each received chip is compared with the local code chip by XNOR, which is the same operation the spreader uses, and the agreements within each 15-chip segment are counted. A segment decodes to 1 when at least 8 of its 15 chips agree with the code and to 0 otherwise, so each message bit survives up to 7 corrupted chips.

Code alignment is not searched for. The sender marks the first chip of every frame with a start flag. The local code restarts on that flag and at every segment boundary, so every segment is compared against code chip 0 onward. Chips may arrive with idle cycles between them. The recovered word is presented with a one-cycle valid pulse and is held until the next frame completes.

Top module: `pn_despreader`

## Requirements
- R1: While reset is high and in the first cycle after it, `msg_out` is 0 and `msg_valid` is 0.
- R2: The local code for every segment is the chip order 0,0,1,0,0,0,1,1,1,1,0,1,0,1,1. A segment whose chips equal this order decodes to 1, and a segment whose chips are its complement decodes to 0.
- R3: A clean frame that is the code three times followed by its complement decodes to `msg_out` = 4'b1110.
- R4: The first segment of a frame gives `msg_out[3]` and the last gives `msg_out[0]`. Every 4-bit word spread by XNOR with the code, one message bit per 15 chips, decodes back to itself.
- R5: A segment decodes to 1 exactly when 8 or more of its chips equal the code chip at the same position. Up to 7 flipped chips in a segment leave its bit unchanged, and 8 flipped chips invert it.
- R6: `msg_valid` goes high for exactly one cycle, in the cycle after the clock edge that accepts the 60th chip of a frame. Cycles with `chip_valid` low take no chip, so idle gaps inside a frame do not shift alignment.
- R7: Chips accepted before any `frame_start` are ignored, and so are chips after a frame has completed and before the next `frame_start`. A `frame_start` in the middle of a frame discards the partial frame and starts a new frame at that chip.
- R8: `msg_out` changes only in a cycle where `msg_valid` is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_in | input | 1 | Received chip |
| chip_valid | input | 1 | `chip_in` carries a chip in this cycle |
| frame_start | input | 1 | With `chip_valid`, marks chip 0 of a frame |
| msg_out | output | 4 | Recovered message, first segment in the MSB |
| msg_valid | output | 1 | One-cycle pulse when `msg_out` is updated |

## Verification
The hardest case to reach is a segment that sits exactly on the decision threshold, with 7 or 8 chip errors. A random word spread cleanly almost never gets there. The stimulus corrupts chosen positions in each segment: up to 7 random distinct flips, which must not change the result, and exactly 8 flips, which must invert that bit. Further frames restart in the middle of a frame, carry random idle gaps, or arrive with no start flag, so that alignment bookkeeping is tested separately from the decision.

// File: rtl/despread_pkg.sv
package despread_pkg;
  localparam int CODE_LEN = 15;
  localparam int MSG_BITS = 4;
  localparam int LFSR_W   = 4;
  // state {s[n+3],s[n+2],s[n+1],s[n]}, chip = state[0]
  localparam logic [LFSR_W-1:0] LFSR_SEED = 4'b0100;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 4'b1001;
  localparam int AGREE_MIN = 8;
endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int                W    = despread_pkg::LFSR_W,
  parameter logic [W-1:0]      SEED = despread_pkg::LFSR_SEED,
  parameter logic [W-1:0]      TAPS = despread_pkg::LFSR_TAPS
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic advance,
  input  logic wrap,
  output logic code_chip
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_eff;
  logic [W-1:0] st_next;

  always_comb begin
    st_eff    = restart ? SEED : st_q;
    code_chip = st_eff[0];
    st_next   = {^(st_eff & TAPS), st_eff[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SEED;
    end else if (restart || advance) begin
      if (advance && wrap) st_q <= SEED;
      else if (advance)    st_q <= st_next;
      else                 st_q <= SEED;
    end
  end
endmodule

// File: rtl/seg_tracker.sv
module seg_tracker #(
  parameter int CHIPS = despread_pkg::CODE_LEN,
  parameter int SEGS  = despread_pkg::MSG_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic beat,
  input  logic start,
  output logic take,
  output logic seg_end,
  output logic frame_end
);
  localparam int IDX_W = $clog2(CHIPS);
  localparam int SEG_W = (SEGS > 1) ? $clog2(SEGS) : 1;

  logic [IDX_W-1:0] idx_q, idx_eff;
  logic [SEG_W-1:0] seg_q, seg_eff;
  logic             active_q;

  always_comb begin
    idx_eff   = start ? '0 : idx_q;
    seg_eff   = start ? '0 : seg_q;
    take      = beat && (start || active_q);
    seg_end   = (idx_eff == IDX_W'(CHIPS - 1));
    frame_end = seg_end && (seg_eff == SEG_W'(SEGS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      seg_q    <= '0;
      active_q <= 1'b0;
    end else if (take) begin
      if (frame_end) begin
        idx_q    <= '0;
        seg_q    <= '0;
        active_q <= 1'b0;
      end else if (seg_end) begin
        idx_q    <= '0;
        seg_q    <= seg_eff + 1'b1;
        active_q <= 1'b1;
      end else begin
        idx_q    <= idx_eff + 1'b1;
        seg_q    <= seg_eff;
        active_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bit_decider.sv
module bit_decider #(
  parameter int CHIPS  = despread_pkg::CODE_LEN,
  parameter int BITS   = despread_pkg::MSG_BITS,
  parameter int THRESH = despread_pkg::AGREE_MIN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            restart,
  input  logic            seg_end,
  input  logic            frame_end,
  input  logic            chip_in,
  input  logic            code_chip,
  output logic [BITS-1:0] msg,
  output logic            msg_valid
);
  localparam int CNT_W = $clog2(CHIPS + 1);

  logic [CNT_W-1:0] agree_q, agree_tot;
  logic [BITS-1:0]  sr_q;
  logic             match, bit_dec;

  always_comb begin
    match     = ~(chip_in ^ code_chip);
    agree_tot = (restart ? '0 : agree_q) + CNT_W'(match);
    bit_dec   = (agree_tot >= CNT_W'(THRESH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      agree_q   <= '0;
      sr_q      <= '0;
      msg       <= '0;
      msg_valid <= 1'b0;
    end else begin
      msg_valid <= 1'b0;
      if (take) begin
        if (seg_end) begin
          agree_q <= '0;
          sr_q    <= {sr_q[BITS-2:0], bit_dec};
          if (frame_end) begin
            msg       <= {sr_q[BITS-2:0], bit_dec};
            msg_valid <= 1'b1;
          end
        end else begin
          agree_q <= agree_tot;
        end
      end
    end
  end
endmodule

// File: rtl/pn_despreader.sv
module pn_despreader #(
  parameter int CHIPS  = despread_pkg::CODE_LEN,
  parameter int BITS   = despread_pkg::MSG_BITS,
  parameter int THRESH = despread_pkg::AGREE_MIN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            chip_in,
  input  logic            chip_valid,
  input  logic            frame_start,
  output logic [BITS-1:0] msg_out,
  output logic            msg_valid
);
  logic take, seg_end, frame_end, code_chip, restart;

  assign restart = chip_valid && frame_start;

  seg_tracker #(.CHIPS(CHIPS), .SEGS(BITS)) u_track (
    .clk(clk), .rst(rst), .beat(chip_valid), .start(frame_start),
    .take(take), .seg_end(seg_end), .frame_end(frame_end)
  );

  pn_lfsr u_code (
    .clk(clk), .rst(rst), .restart(restart), .advance(take),
    .wrap(seg_end), .code_chip(code_chip)
  );

  bit_decider #(.CHIPS(CHIPS), .BITS(BITS), .THRESH(THRESH)) u_dec (
    .clk(clk), .rst(rst), .take(take), .restart(restart),
    .seg_end(seg_end), .frame_end(frame_end), .chip_in(chip_in),
    .code_chip(code_chip), .msg(msg_out), .msg_valid(msg_valid)
  );
endmodule

// File: rtl/pn_despreader_chk.sv
module pn_despreader_chk #(
  parameter int CHIPS = despread_pkg::CODE_LEN,
  parameter int BITS  = despread_pkg::MSG_BITS
) (
  input logic            clk,
  input logic            rst,
  input logic            chip_valid,
  input logic            frame_start,
  input logic [BITS-1:0] msg_out,
  input logic            msg_valid
);
  localparam int FRAME = CHIPS * BITS;
  localparam int CW    = $clog2(FRAME + 2);

  logic [CW-1:0] beats_q;

  always_ff @(posedge clk) begin
    if (rst) beats_q <= '0;
    else if (chip_valid && frame_start) beats_q <= CW'(1);
    else if (chip_valid && beats_q != '0 && beats_q != CW'(FRAME + 1))
      beats_q <= beats_q + 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (msg_out == '0 && !msg_valid));

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid |=> !msg_valid);

  // R6
  valid_after_chip_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> $past(chip_valid));

  // R7
  frame_count_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> beats_q == CW'(FRAME));

  // R8
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !msg_valid |-> $stable(msg_out));
endmodule

bind pn_despreader pn_despreader_chk #(.CHIPS(CHIPS), .BITS(BITS)) u_chk (
  .clk(clk), .rst(rst), .chip_valid(chip_valid), .frame_start(frame_start),
  .msg_out(msg_out), .msg_valid(msg_valid)
);

// File: tb/pn_despreader_test.sv
module pn_despreader_test;
  localparam logic [14:0] CODE = 15'b001000111101011; // chip 0 in bit 14

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chip_in = 1'b0, chip_valid = 1'b0, frame_start = 1'b0;
  logic [3:0] msg_out;
  logic       msg_valid;

  int checks = 0, errors = 0, valids = 0;
  logic prev_valid = 1'b0;
  logic [3:0] expq[$];
  logic       done = 1'b0;
  logic [3:0] last_msg = 4'd0;

  always #4 clk = ~clk;

  pn_despreader uut (.clk(clk), .rst(rst), .chip_in(chip_in), .chip_valid(chip_valid),
                     .frame_start(frame_start), .msg_out(msg_out), .msg_valid(msg_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected words as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (msg_valid) begin
        valids++;
        chk(!prev_valid, "R6 pulse width", 1, 0);
        if (expq.size() == 0) chk(0, "R7 unexpected result", msg_out, -1);
        else begin
          logic [3:0] e;
          e = expq.pop_front();
          chk(msg_out == e, "R4/R5 decoded word", msg_out, e);
          last_msg = e;
        end
      end
      prev_valid <= msg_valid;
    end
  end

  task automatic put_chip(input logic c, input logic st, input bit gaps);
    if (gaps && ($urandom_range(0, 3) == 0)) begin
      chip_valid = 1'b0; frame_start = st ^ 1'b1; chip_in = ~c;
      @(negedge clk);
    end
    chip_in = c; chip_valid = 1'b1; frame_start = st;
    @(negedge clk);
    chip_valid = 1'b0; frame_start = 1'b0;
  endtask

  // flips: 4 segment masks, bit 14 is chip 0
  task automatic send_frame(input logic [3:0] m, input logic [14:0] f [4],
                            input logic [3:0] exp, input bit gaps);
    expq.push_back(exp);
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 15; i++)
        put_chip(~(m[3-s] ^ CODE[14-i]) ^ f[s][14-i], (s == 0 && i == 0), gaps);
  endtask

  function automatic logic [14:0] rand_mask(input int k);
    logic [14:0] mk = '0;
    while ($countones(mk) < k) mk[$urandom_range(0, 14)] = 1'b1;
    return mk;
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [14:0] z [4];
    logic [14:0] f [4];
    int v0;
    for (int s = 0; s < 4; s++) z[s] = '0;
    repeat (3) @(negedge clk);
    chk(msg_out == 0 && msg_valid == 0, "R1 in reset", {msg_valid, msg_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(msg_out == 0 && msg_valid == 0, "R1 after reset", {msg_valid, msg_out}, 0);

    // R7: chips with no frame start are ignored
    v0 = valids;
    for (int i = 0; i < 40; i++) put_chip($urandom_range(0, 1), 1'b0, 1'b0);
    settle();
    chk(valids == v0, "R7 no start", valids - v0, 0);

    // R3: code x3 then complement
    send_frame(4'b1110, z, 4'b1110, 1'b0);
    settle();
    chk(msg_out == 4'b1110, "R3 frame 1110", msg_out, 14);

    // R2: all-code and all-complement frames
    send_frame(4'b1111, z, 4'b1111, 1'b0);
    send_frame(4'b0000, z, 4'b0000, 1'b0);
    settle();
    chk(msg_out == 4'b0000, "R2 complement frame", msg_out, 0);

    // R4: every word, clean, with gaps
    for (int w = 0; w < 16; w++) send_frame(4'(w), z, 4'(w), 1'b1);
    settle();

    // R6: valid exactly one cycle after 60th chip
    expq.push_back(4'b1010);
    for (int c = 0; c < 60; c++)
      put_chip(~(((c / 15) % 2 == 0) ^ CODE[14 - (c % 15)]), c == 0, 1'b0);
    chk(msg_valid == 1'b1, "R6 timing", msg_valid, 1);
    settle();

    // R5: up to 7 random flips per segment tolerated
    for (int t = 0; t < 30; t++) begin
      logic [3:0] w;
      w = 4'($urandom_range(0, 15));
      for (int s = 0; s < 4; s++) f[s] = rand_mask($urandom_range(0, 7));
      send_frame(w, f, w, 1'b1);
    end
    for (int s = 0; s < 4; s++) f[s] = rand_mask(7);
    send_frame(4'b0110, f, 4'b0110, 1'b0);
    // R5: exactly 8 flips in one segment invert that bit
    for (int s = 0; s < 4; s++) begin
      for (int q = 0; q < 4; q++) f[q] = (q == s) ? rand_mask(8) : 15'd0;
      send_frame(4'b1001, f, 4'b1001 ^ (4'b1000 >> s), 1'b0);
    end
    settle();

    // R7: mid-frame restart discards partial frame
    for (int i = 0; i < 23; i++) put_chip($urandom_range(0, 1), i == 0, 1'b0);
    send_frame(4'b0101, z, 4'b0101, 1'b1);
    settle();
    chk(msg_out == 4'b0101, "R7 restart", msg_out, 5);

    // R8: output holds while idle and during ignored chips
    for (int i = 0; i < 20; i++) put_chip($urandom_range(0, 1), 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk(msg_out == last_msg, "R8 hold", msg_out, last_msg);
    chk(expq.size() == 0, "R6 all results seen", expq.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule